// File: doc/BRIEF.md
# SD Card Data FIFO and Byte Packer

This block sits between a 32-bit register port and the byte-wide data stream of an SD card. Software moves whole words through a sixteen-word circular FIFO. A transfer engine moves one card byte per clock. In the read direction it gathers incoming card bytes into words, lowest byte first, and pushes each complete word into the FIFO. In the write direction it pops words from the FIFO and sends their bytes to the card, lowest byte first.

A transfer is armed by writing a block count. The remaining-byte counter then loads with the block count multiplied by the programmed block size. Status bits record FIFO activity and block boundaries, and a combined interrupt is driven from the enabled ones. A debug register shows the live FIFO level. Its state field returns to the data-mode code when a transfer finishes.

The engine FSM has four states. IDLE waits for a nonzero count and a direction. PACK accepts card bytes. FETCH pops the next word for sending. SHIFT presents the bytes of the held word. The transitions are as follows:
- arm-read (IDLE to PACK) and arm-write (IDLE to FETCH) fire when the count is nonzero and the direction field matches.
- drop-read (PACK to IDLE) and drop-write (FETCH to IDLE) fire when the direction field changes.
- pack-done (PACK to IDLE) fires on the last byte.
- fetch-hit (FETCH to SHIFT) fires when a word is popped.
- word-spent (SHIFT to FETCH) fires after the fourth byte.
- send-done (SHIFT to IDLE) fires on the last byte.
- reload (any state to IDLE) fires on a block-count write.

Top module: `sdf_datapath`

## Requirements
- R1: After reset, STATUS (address 1) reads 0, CTRL (address 2) reads 0, DEBUG (address 5) reads 0x0000C60F, and irq, rx_ready and tx_valid are low.
- R2: The FIFO holds 16 words in arrival order. A write to DATA (address 0) when 16 words are held is discarded. A read of DATA pops the oldest word, and it returns 0 without any change when the FIFO is empty.
- R3: A write to BCOUNT (address 4, bits 8:0) sets the remaining byte count to the written value times BSIZE (address 3, bits 11:0). It also discards any partly gathered or partly sent word, and the engine restarts from IDLE.
- R4: When CTRL[1:0]=01 and bytes remain, rx_ready is high exactly when the FIFO holds fewer than 16 words and no DATA write is in the same cycle. Each accepted byte k of a word is placed at bits 8k+7:8k. The word is pushed after its fourth byte.
- R5: When the last byte of a read transfer is accepted, a partly gathered word is pushed in that same cycle with its unfilled upper bytes zero.
- R6: When CTRL[1:0]=10 and bytes remain, the engine pops a word (waiting while the FIFO is empty) and offers its bytes on tx_data lowest first, one per tx handshake. It stops when the count reaches zero, and any unsent bytes of the last word are dropped.
- R7: Every engine push or pop sets STATUS bit 0. When CTRL bit 2 is set, it also sets STATUS bit 1.
- R8: In the write direction with CTRL bit 3 set and a nonzero BSIZE, STATUS bit 2 is set each time the remaining count becomes a multiple of BSIZE.
- R9: irq is STATUS bit 1 OR STATUS bit 2. Writing STATUS clears each bit written as 1, and a set in the same cycle takes precedence.
- R10: DEBUG bits 8:4 read the current FIFO level. DEBUG bits 3:0 become 1 when a transfer's count reaches zero.
- R11: A DEBUG write stores bits 31:9 and 3:0, except that a value of 0xF in bits 3:0 is stored as 0.
- R12: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Combined enabled interrupt |
| rx_valid | input | 1 | Card byte available |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| tx_valid | output | 1 | Byte offered to the card |
| tx_data | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card takes the byte |

## Verification
Read transfers use an interrupted byte source with lengths that are whole words (80 bytes), that end on a partial word (6 bytes) and that are cut short by a reload. These separate correct lane placement, zero padding of the tail word and the discard of a half-gathered word. The 80-byte run overfills the FIFO, so rx_ready back-pressure is exercised against software draining at a slower rate. Write transfers run against a card that stalls every third cycle. They cover words pushed only after arming (the wait in FETCH), a block size of four with the block interrupt, and a 5-byte length that leaves three bytes of the last word unsent. Because every port is compared against a queue-based model on every clock, a wrong byte order, an early pop or a misplaced block flag shows up in the cycle where it happens.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int DBG_LVL_W = 5;

    localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_BSIZE  = 3'd3;
    localparam logic [ADDR_W-1:0] A_BCOUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_DEBUG  = 3'd5;

    localparam logic [1:0] DIR_READ  = 2'b01;
    localparam logic [1:0] DIR_WRITE = 2'b10;

    localparam logic [DATA_W-1:0] DEBUG_RESET = 32'h0000_C60F;
    localparam logic [3:0]        DBG_DATAMODE = 4'h1;
    localparam logic [3:0]        DBG_PWRDOWN  = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PACK,
        ST_FETCH,
        ST_SHIFT
    } eng_state_t;

endpackage

// File: rtl/sdf_fifo.sv
module sdf_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] pos_q;
    logic [LVL_W-1:0] cnt_q;
    logic             take_push;
    logic             take_pop;
    logic [PTR_W-1:0] slot;

    // a push to a full store and a pop from an empty one are ignored
    assign take_push = push && (cnt_q != LVL_W'(DEPTH));
    assign take_pop  = pop  && (cnt_q != '0);
    assign slot      = pos_q + cnt_q[PTR_W-1:0];

    always_ff @(posedge clk) begin
        if (take_push) begin
            mem[slot] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            cnt_q <= '0;
        end else begin
            if (take_pop) begin
                pos_q <= pos_q + PTR_W'(1);
            end
            unique case ({take_push, take_pop})
                2'b10:   cnt_q <= cnt_q + LVL_W'(1);
                2'b01:   cnt_q <= cnt_q - LVL_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = (cnt_q == '0) ? '0 : mem[pos_q];
    assign level = cnt_q;

endmodule

// File: rtl/sdf_engine.sv
module sdf_engine
    import sdf_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int REM_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dir,
    input  logic              load,
    input  logic [REM_W-1:0]  load_bytes,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic              sw_push,
    input  logic              sw_pop,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              eng_push,
    output logic [DATA_W-1:0] eng_word,
    output logic              eng_pop,
    output logic              ev_data,
    output logic              ev_block,
    output logic              ev_done
);
    eng_state_t        state, nxt;
    logic [REM_W-1:0]  remain;
    logic [SIZE_W-1:0] blk_left;
    logic [1:0]        pk_idx;
    logic [DATA_W-1:0] pk_acc;
    logic [DATA_W-1:0] sh_word;
    logic [1:0]        sh_idx;
    logic              rx_fire;
    logic              tx_fire;
    logic              last_byte;

    assign last_byte = (remain == REM_W'(1));

    // outputs of the state machine
    always_comb begin
        rx_ready = (state == ST_PACK) && (dir == DIR_READ) && !fifo_full && !sw_push;
        rx_fire  = rx_valid && rx_ready;
        eng_word = pk_acc | ({24'b0, rx_data} << {pk_idx, 3'b000});
        eng_push = rx_fire && ((pk_idx == 2'd3) || last_byte);
        eng_pop  = (state == ST_FETCH) && (dir == DIR_WRITE) && !fifo_empty && !sw_pop;
        tx_valid = (state == ST_SHIFT);
        tx_data  = sh_word[7:0];
        tx_fire  = tx_valid && tx_ready;
        ev_data  = eng_push || eng_pop;
        ev_block = tx_fire && (blk_size != '0) && (blk_left == SIZE_W'(1));
        ev_done  = (rx_fire || tx_fire) && last_byte;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (remain != '0) begin
                    if (dir == DIR_READ) begin
                        nxt = ST_PACK;          // arm-read
                    end else if (dir == DIR_WRITE) begin
                        nxt = ST_FETCH;         // arm-write
                    end
                end
            end
            ST_PACK: begin
                if (dir != DIR_READ) begin
                    nxt = ST_IDLE;              // drop-read
                end else if (rx_fire && last_byte) begin
                    nxt = ST_IDLE;              // pack-done
                end
            end
            ST_FETCH: begin
                if (dir != DIR_WRITE) begin
                    nxt = ST_IDLE;              // drop-write
                end else if (eng_pop) begin
                    nxt = ST_SHIFT;             // fetch-hit
                end
            end
            ST_SHIFT: begin
                if (tx_fire) begin
                    if (last_byte) begin
                        nxt = ST_IDLE;          // send-done
                    end else if (sh_idx == 2'd3) begin
                        nxt = ST_FETCH;         // word-spent
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (load) begin
            nxt = ST_IDLE;                      // reload
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // byte counters and packing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain   <= '0;
            blk_left <= '0;
            pk_idx   <= '0;
            pk_acc   <= '0;
            sh_word  <= '0;
            sh_idx   <= '0;
        end else if (load) begin
            remain   <= load_bytes;
            blk_left <= blk_size;
            pk_idx   <= '0;
            pk_acc   <= '0;
            sh_word  <= '0;
            sh_idx   <= '0;
        end else begin
            if (rx_fire) begin
                remain <= remain - REM_W'(1);
                if (eng_push) begin
                    pk_idx <= '0;
                    pk_acc <= '0;
                end else begin
                    pk_idx <= pk_idx + 2'd1;
                    pk_acc <= eng_word;
                end
            end
            if (eng_pop) begin
                sh_word <= fifo_head;
                sh_idx  <= '0;
            end
            if (tx_fire) begin
                remain   <= remain - REM_W'(1);
                sh_word  <= {8'b0, sh_word[DATA_W-1:8]};
                sh_idx   <= sh_idx + 2'd1;
                blk_left <= (blk_left == SIZE_W'(1)) ? blk_size : blk_left - SIZE_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdf_regs.sv
module sdf_regs
    import sdf_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int BCNT_W = 9,
    parameter int REM_W  = 21,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              ev_data,
    input  logic              ev_block,
    input  logic              ev_done,
    output logic [1:0]        dir,
    output logic              load,
    output logic [REM_W-1:0]  load_bytes,
    output logic [SIZE_W-1:0] blk_size,
    output logic              sw_push,
    output logic              sw_pop
);
    logic [3:0]        ctrl_q;
    logic [2:0]        stat_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [DATA_W-1:0] dbg_q;
    logic [2:0]        stat_set;
    logic [2:0]        stat_clr;
    logic [DATA_W-1:0] dbg_wval;
    logic [DATA_W-1:0] dbg_view;
    logic              wr_stat;
    logic              wr_dbg;

    assign dir        = ctrl_q[1:0];
    assign sw_push    = reg_wr && (reg_addr == A_DATA);
    assign sw_pop     = reg_rd && (reg_addr == A_DATA);
    assign load       = reg_wr && (reg_addr == A_BCOUNT);
    assign load_bytes = REM_W'(reg_wdata[BCNT_W-1:0]) * REM_W'(blk_size);
    assign wr_stat    = reg_wr && (reg_addr == A_STATUS);
    assign wr_dbg     = reg_wr && (reg_addr == A_DEBUG);

    assign stat_set = {ev_block && ctrl_q[3], ev_data && ctrl_q[2], ev_data};
    assign stat_clr = wr_stat ? reg_wdata[2:0] : 3'b000;
    assign irq      = stat_q[1] | stat_q[2];

    always_comb begin
        dbg_wval      = reg_wdata;
        dbg_wval[8:4] = '0;
        if (reg_wdata[3:0] == DBG_PWRDOWN) begin
            dbg_wval[3:0] = '0;
        end
    end

    assign dbg_view = {dbg_q[DATA_W-1:9], DBG_LVL_W'(fifo_level), dbg_q[3:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            stat_q   <= '0;
            blk_size <= '0;
            bcnt_q   <= '0;
            dbg_q    <= DEBUG_RESET;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (reg_wr && (reg_addr == A_CTRL)) begin
                ctrl_q <= reg_wdata[3:0];
            end
            if (reg_wr && (reg_addr == A_BSIZE)) begin
                blk_size <= reg_wdata[SIZE_W-1:0];
            end
            if (load) begin
                bcnt_q <= reg_wdata[BCNT_W-1:0];
            end
            if (wr_dbg) begin
                dbg_q <= dbg_wval;
            end
            if (ev_done) begin
                dbg_q[3:0] <= DBG_DATAMODE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                A_DATA:   reg_rdata <= fifo_head;
                A_STATUS: reg_rdata <= DATA_W'(stat_q);
                A_CTRL:   reg_rdata <= DATA_W'(ctrl_q);
                A_BSIZE:  reg_rdata <= DATA_W'(blk_size);
                A_BCOUNT: reg_rdata <= DATA_W'(bcnt_q);
                A_DEBUG:  reg_rdata <= dbg_view;
                default:  reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/sdf_datapath.sv
module sdf_datapath
    import sdf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int SIZE_W = 12,
    parameter int BCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);
    localparam int REM_W = SIZE_W + BCNT_W;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [1:0]        dir;
    logic              load;
    logic [REM_W-1:0]  load_bytes;
    logic [SIZE_W-1:0] blk_size;
    logic              sw_push;
    logic              sw_pop;
    logic              eng_push;
    logic              eng_pop;
    logic [DATA_W-1:0] eng_word;
    logic              ev_data;
    logic              ev_block;
    logic              ev_done;
    logic [DATA_W-1:0] fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_full;
    logic              fifo_empty;

    assign fifo_full  = (fifo_level == LVL_W'(DEPTH));
    assign fifo_empty = (fifo_level == '0);

    sdf_regs #(
        .SIZE_W (SIZE_W),
        .BCNT_W (BCNT_W),
        .REM_W  (REM_W),
        .LVL_W  (LVL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .fifo_head  (fifo_head),
        .fifo_level (fifo_level),
        .ev_data    (ev_data),
        .ev_block   (ev_block),
        .ev_done    (ev_done),
        .dir        (dir),
        .load       (load),
        .load_bytes (load_bytes),
        .blk_size   (blk_size),
        .sw_push    (sw_push),
        .sw_pop     (sw_pop)
    );

    sdf_fifo #(
        .DEPTH (DEPTH),
        .DW    (DATA_W),
        .LVL_W (LVL_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sw_push || eng_push),
        .push_data (eng_push ? eng_word : reg_wdata),
        .pop       (sw_pop || eng_pop),
        .head      (fifo_head),
        .level     (fifo_level)
    );

    sdf_engine #(
        .SIZE_W (SIZE_W),
        .REM_W  (REM_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir        (dir),
        .load       (load),
        .load_bytes (load_bytes),
        .blk_size   (blk_size),
        .sw_push    (sw_push),
        .sw_pop     (sw_pop),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .eng_push   (eng_push),
        .eng_word   (eng_word),
        .eng_pop    (eng_pop),
        .ev_data    (ev_data),
        .ev_block   (ev_block),
        .ev_done    (ev_done)
    );

endmodule

// File: rtl/sdf_datapath_chk.sv
module sdf_datapath_chk
    import sdf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic [LVL_W-1:0]  level
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R2
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + LVL_W'(1)) ||
        ($past(level) == level + LVL_W'(1)));

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == A_DATA) && (level == '0)) |=> (reg_rdata == '0));

    // R12
    tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(reg_wr && (reg_addr == A_BCOUNT)))
        |=> (tx_valid && $stable(tx_data)));

    // R4
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    // R4
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH)) |-> !rx_ready);

endmodule

bind sdf_datapath sdf_datapath_chk #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .level     (fifo_level)
);

// File: tb/sim_sdf_datapath.sv
`timescale 1ns/1ps
module sim_sdf_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    always #2.5 clk = ~clk;

    sdf_datapath u0 (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq (irq), .rx_valid (rx_valid), .rx_data (rx_data), .rx_ready (rx_ready),
        .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string tag = "R1";
    bit    rx_en = 1'b0;
    int    src_n = 0;

    // behavioural reference
    logic [31:0] m_q[$];
    logic [7:0]  m_pack[$];
    logic [7:0]  m_bytes[$];
    int          m_st;
    int          m_rem;
    int          m_bsize;
    int          m_bcnt;
    logic [3:0]  m_ctrl;
    logic [2:0]  m_stat;
    logic [31:0] m_dbg;
    bit          rd_pend = 1'b0;
    logic [31:0] rd_exp;
    string       rd_tag;

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", t, act, exp, cyc);
        end
    endtask

    function automatic bit exp_rx_ready();
        return (m_st == 1) && (m_ctrl[1:0] == 2'b01) && (m_q.size() < 16) &&
               !(reg_wr && reg_addr == 3'd0);
    endfunction

    always @(posedge clk) begin
        bit          rdy, rxf, txf, swpush, swpop, epop, epush, done, blk;
        int          pre, nst;
        logic [31:0] head, eword, rv;
        logic [2:0]  set;
        cyc++;
        if (!rst_n) begin
            m_q.delete(); m_pack.delete(); m_bytes.delete();
            m_st = 0; m_rem = 0; m_bsize = 0; m_bcnt = 0;
            m_ctrl = '0; m_stat = '0; m_dbg = 32'h0000_C60F;
            rd_pend = 1'b0;
        end else begin
            rdy    = exp_rx_ready();
            rxf    = rx_valid && rdy;
            txf    = (m_st == 3) && tx_ready;
            pre    = m_q.size();
            head   = (pre > 0) ? m_q[0] : 32'h0;
            swpush = reg_wr && reg_addr == 3'd0;
            swpop  = reg_rd && reg_addr == 3'd0;
            epop   = (m_st == 2) && (m_ctrl[1:0] == 2'b10) && (pre > 0) && !swpop;
            epush  = 1'b0; done = 1'b0; blk = 1'b0; eword = '0;
            nst    = m_st;
            if (reg_rd) begin
                case (reg_addr)
                    3'd0: rv = head;
                    3'd1: rv = {29'b0, m_stat};
                    3'd2: rv = {28'b0, m_ctrl};
                    3'd3: rv = 32'(m_bsize);
                    3'd4: rv = 32'(m_bcnt);
                    3'd5: rv = {m_dbg[31:9], 5'(pre), m_dbg[3:0]};
                    default: rv = '0;
                endcase
                rd_exp = rv; rd_pend = 1'b1; rd_tag = tag;
            end
            if (reg_wr && reg_addr == 3'd4) begin
                m_rem = (reg_wdata & 32'h1ff) * m_bsize;
                m_pack.delete(); m_bytes.delete();
                nst = 0;
            end else begin
                case (m_st)
                    0: if (m_rem != 0) begin
                           if (m_ctrl[1:0] == 2'b01) nst = 1;
                           else if (m_ctrl[1:0] == 2'b10) nst = 2;
                       end
                    1: if (m_ctrl[1:0] != 2'b01) nst = 0;
                       else if (rxf) begin
                           m_pack.push_back(rx_data);
                           m_rem--; src_n++;
                           if (m_pack.size() == 4 || m_rem == 0) begin
                               epush = 1'b1;
                               foreach (m_pack[i]) eword |= 32'(m_pack[i]) << (8 * i);
                               m_pack.delete();
                           end
                           if (m_rem == 0) begin nst = 0; done = 1'b1; end
                       end
                    2: if (m_ctrl[1:0] != 2'b10) nst = 0;
                       else if (epop) begin
                           for (int k = 0; k < 4; k++) m_bytes.push_back(head[8*k +: 8]);
                           nst = 3;
                       end
                    default: if (txf) begin
                           void'(m_bytes.pop_front());
                           m_rem--;
                           if (m_bsize != 0 && (m_rem % m_bsize) == 0) blk = 1'b1;
                           if (m_rem == 0) begin nst = 0; done = 1'b1; m_bytes.delete(); end
                           else if (m_bytes.size() == 0) nst = 2;
                       end
                endcase
            end
            if ((swpop || epop) && pre > 0) void'(m_q.pop_front());
            if (swpush && pre < 16) m_q.push_back(reg_wdata);
            if (epush) m_q.push_back(eword);
            set = {blk && m_ctrl[3], (epush || epop) && m_ctrl[2], epush || epop};
            if (reg_wr && reg_addr == 3'd1) m_stat = m_stat & ~reg_wdata[2:0];
            m_stat = m_stat | set;
            if (reg_wr && reg_addr == 3'd5) begin
                m_dbg = reg_wdata; m_dbg[8:4] = '0;
                if (reg_wdata[3:0] == 4'hF) m_dbg[3:0] = '0;
            end
            if (done) m_dbg[3:0] = 4'h1;
            if (reg_wr && reg_addr == 3'd2) m_ctrl = reg_wdata[3:0];
            if (reg_wr && reg_addr == 3'd3) m_bsize = int'(reg_wdata[11:0]);
            if (reg_wr && reg_addr == 3'd4) m_bcnt = int'(reg_wdata[8:0]);
            m_st = nst;
        end
    end

    // card side stimulus
    always @(negedge clk) begin
        rx_data  <= 8'(src_n * 7 + 3);
        rx_valid <= rx_en && ((cyc % 5) != 4);
        tx_ready <= (cyc % 3) != 2;
    end

    // compare every clock
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(rx_ready == exp_rx_ready(), "R4 rx_ready", 32'(rx_ready), 32'(exp_rx_ready()));
            chk(tx_valid == (m_st == 3), "R6 R12 tx_valid", 32'(tx_valid), 32'(m_st == 3));
            if (tx_valid && m_st == 3)
                chk(tx_data == m_bytes[0], "R6 tx_data", 32'(tx_data), 32'(m_bytes[0]));
            chk(irq == (m_stat[1] | m_stat[2]), "R9 irq", 32'(irq), 32'(m_stat[1] | m_stat[2]));
            if (rd_pend) begin
                chk(reg_rdata == rd_exp, {rd_tag, " rdata"}, reg_rdata, rd_exp);
                rd_pend = 1'b0;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1 reset values
        tag = "R1"; rd(3'd1); rd(3'd5); rd(3'd2);
        // R2 fill past capacity, then drain past empty
        tag = "R2";
        for (int i = 0; i < 17; i++) wr(3'd0, 32'hA000_0000 + i);
        tag = "R10"; rd(3'd5);
        tag = "R2";
        for (int i = 0; i < 17; i++) rd(3'd0);
        // R4 R5 six-byte read ends on a half word
        tag = "R4"; wr(3'd2, 32'h5); wr(3'd3, 32'd6); rx_en = 1'b1; wr(3'd4, 32'd1);
        idle(20);
        tag = "R5"; rd(3'd0); rd(3'd0);
        tag = "R7"; rd(3'd1);
        tag = "R10"; rd(3'd5);
        tag = "R9"; wr(3'd1, 32'h7); rd(3'd1);
        // R4 long read overfills the FIFO
        tag = "R4"; wr(3'd3, 32'd80); wr(3'd4, 32'd1);
        idle(60);
        tag = "R10"; rd(3'd5);
        tag = "R4";
        for (int i = 0; i < 24; i++) begin rd(3'd0); idle(3); end
        // R3 reload abandons a partial word
        tag = "R3"; wr(3'd3, 32'd8); wr(3'd4, 32'd1); idle(3); wr(3'd4, 32'd2);
        idle(40);
        for (int i = 0; i < 5; i++) rd(3'd0);
        rd(3'd4); rd(3'd3);
        rx_en = 1'b0;
        // R6 R8 write direction, words arrive after arming
        tag = "R6"; wr(3'd1, 32'h7); wr(3'd2, 32'hE); wr(3'd3, 32'd4); wr(3'd4, 32'd3);
        idle(5);
        wr(3'd0, 32'h4433_2211); wr(3'd0, 32'h8877_6655); wr(3'd0, 32'hCCBB_AA99);
        idle(40);
        tag = "R8"; rd(3'd1);
        tag = "R9"; wr(3'd1, 32'h2); rd(3'd1); wr(3'd1, 32'h7); rd(3'd1);
        tag = "R10"; rd(3'd5);
        // R6 five bytes leave three unsent
        tag = "R6"; wr(3'd3, 32'd5); wr(3'd4, 32'd1);
        wr(3'd0, 32'h1357_9BDF); wr(3'd0, 32'h2468_ACE0);
        idle(25);
        tag = "R10"; rd(3'd5);
        // R8 block flag only, size three
        tag = "R8"; wr(3'd1, 32'h7); wr(3'd2, 32'hA); wr(3'd3, 32'd3); wr(3'd4, 32'd2);
        wr(3'd0, 32'hDEAD_BEEF); wr(3'd0, 32'h0BAD_F00D);
        idle(30);
        rd(3'd1);
        // R11 state field handling
        tag = "R11"; wr(3'd5, 32'h1234_567F); rd(3'd5); wr(3'd5, 32'h0000_00A3); rd(3'd5);
        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule